// File: doc/BRIEF.md
# DMA Interrupt Control and Status Register

This block is the single interrupt control and status word shared by the seven channels of a DMA controller. Software reaches it on a 32-bit register bus at one fixed offset. Each transfer engine pulses its own completion line when it finishes, and the block sends one interrupt request line to the system interrupt controller.

The word holds a force bit, one enable bit per channel, a master enable for the flags, one sticky completion flag per channel, and a read-only summary bit at the top. The summary is recomputed every cycle from the force bit, the master enable and the flags. An interrupt is raised only when the summary goes from 0 to 1, as a pulse one clock wide. Flags are cleared by writing a 1 to them, so software can acknowledge one channel without disturbing the others. The register bus and the completion lines are plain control pins: a write is taken in the cycle its strobe is high and never stalls, and read data is combinational on the address.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset every register bit reads 0 and the interrupt output is low.
- R2: A write at offset 0x74 loads bit 15 (force), bits 16 to 22 (channel 0 to 6 enables) and bit 23 (master enable) from the write data in the next cycle; bits 0 to 14 always read 0.
- R3: Bit 31 of the write data is ignored; a write can change the summary bit only through the force, master enable and flag bits.
- R4: Writing a 1 to a flag bit (bits 24 to 30, channel n at bit 24+n) clears that flag; writing a 0 leaves it as it was.
- R5: A completion pulse on channel n sets flag n only if enable n (bit 16+n) was set before that clock edge; otherwise it has no effect.
- R6: When a completion pulse and a write of 1 to the same flag arrive in the same cycle on an enabled channel, the flag ends up set.
- R7: Bit 31 reads force OR (master enable AND any flag), reflecting the register state one clock edge earlier.
- R8: The interrupt output is high for exactly one cycle, in the first cycle in which bit 31 reads 1 after reading 0; it stays low while the summary remains 1 or is 0.
- R9: A write to any other offset changes nothing, and a read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ch_done | input | 7 | Per-channel completion pulses, bit n for channel n |
| irq | output | 1 | One-cycle interrupt request to the interrupt controller |

## Verification
The assertions take for granted that completion pulses and bus strobes are synchronous to the clock and hold no unknown values after reset, and that each strobe names one access; they place no limit on pulses on several channels at once or on completions that coincide with writes. The stimulus is driven on the falling edge, so every input is settled at the sampling edge, and it deliberately lines up completions with clearing writes, disables channels while they complete and rewrites the top bit so the collision and ignore rules are all reached.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 8;
  localparam int CH_DEFAULT = 7;
  localparam int FORCE_POS  = 15;
  localparam int SUM_POS    = DATA_W - 1;
  localparam logic [ADDR_W-1:0] CSR_OFFSET = 8'h74;
endpackage

// File: rtl/dma_irq_flag.sv
module dma_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic done_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q;
  logic set_w;

  assign set_w = done_i & enable_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (set_w) begin
      flag_q <= 1'b1;
    end else if (ack_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  a_r5_set_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && enable_i) |=> flag_o);

  a_r5_no_set_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o && !(done_i && enable_i)) |=> !flag_o);

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !(done_i && enable_i)) |=> !flag_o);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_i && !done_i) |=> $stable(flag_o));
endmodule

// File: rtl/dma_irq_summary.sv
module dma_irq_summary #(
  parameter int NUM_CH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_i,
  input  logic              master_i,
  input  logic [NUM_CH-1:0] flags_i,
  output logic              sum_o,
  output logic              irq_o
);
  logic sum_next;
  logic sum_q;
  logic irq_q;

  assign sum_next = force_i | (master_i & (|flags_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      sum_q <= sum_next;
      irq_q <= sum_next & ~sum_q;
    end
  end

  assign sum_o = sum_q;
  assign irq_o = irq_q;

  a_r8_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (sum_o && !$past(sum_o)));

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  a_r8_rise_fires: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum_o) |-> irq_o);

  a_r7_force_wins: assert property (@(posedge clk) disable iff (!rst_n)
    force_i |=> sum_o);

  a_r7_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_i && !master_i) |=> !sum_o);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = CH_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] ch_done,
  output logic              irq
);
  localparam int EN_LSB  = FORCE_POS + 1;
  localparam int MEN_POS = EN_LSB + NUM_CH;
  localparam int FL_LSB  = MEN_POS + 1;

  logic              hit;
  logic              wr_hit;
  logic              force_q;
  logic              master_q;
  logic [NUM_CH-1:0] enable_q;
  logic [NUM_CH-1:0] flags;
  logic [NUM_CH-1:0] ack;
  logic              sum;
  logic              unused_wbits;

  assign hit    = (bus_addr == CSR_OFFSET);
  assign wr_hit = bus_we & hit;
  assign unused_wbits = ^{bus_wdata[FORCE_POS-1:0], bus_wdata[DATA_W-1:FL_LSB+NUM_CH]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_q  <= 1'b0;
      master_q <= 1'b0;
      enable_q <= '0;
    end else if (wr_hit) begin
      force_q  <= bus_wdata[FORCE_POS];
      master_q <= bus_wdata[MEN_POS];
      enable_q <= bus_wdata[EN_LSB +: NUM_CH];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ack[c] = wr_hit & bus_wdata[FL_LSB + c];
    dma_irq_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (enable_q[c]),
      .done_i   (ch_done[c]),
      .ack_i    (ack[c]),
      .flag_o   (flags[c])
    );
  end

  dma_irq_summary #(.NUM_CH(NUM_CH)) u_sum (
    .clk      (clk),
    .rst_n    (rst_n),
    .force_i  (force_q),
    .master_i (master_q),
    .flags_i  (flags),
    .sum_o    (sum),
    .irq_o    (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      bus_rdata[FORCE_POS]          = force_q;
      bus_rdata[EN_LSB +: NUM_CH]   = enable_q;
      bus_rdata[MEN_POS]            = master_q;
      bus_rdata[FL_LSB +: NUM_CH]   = flags;
      bus_rdata[SUM_POS]            = sum;
    end
  end

  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (force_q == $past(bus_wdata[FORCE_POS]) &&
                master_q == $past(bus_wdata[MEN_POS])));

  a_r9_miss_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit) |=> ($stable(force_q) && $stable(master_q) && $stable(enable_q)));

  a_r9_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (bus_rdata == '0));

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[FORCE_POS-1:0] == '0);
endmodule

// File: tb/dma_irq_ctrl_tb_top.sv
module dma_irq_ctrl_tb_top;
  localparam int NCH = 7;
  localparam int WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h74;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  ch_done = '0;
  logic        irq;

  always #2.5 clk = ~clk;

  dma_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_done(ch_done), .irq(irq)
  );

  // behavioural reference
  bit       m_force, m_master, m_sum, m_irq;
  bit [6:0] m_en, m_fl;
  int       vectors = 0;
  int       misses = 0;
  int       cycles = 0;
  string    tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_force = 0; m_master = 0; m_sum = 0; m_irq = 0; m_en = '0; m_fl = '0;
    end else begin
      bit ns;
      bit wr;
      ns = m_force || (m_master && (m_fl != 0));
      m_irq = ns && !m_sum;
      m_sum = ns;
      wr = bus_we && (bus_addr == 8'h74);
      for (int c = 0; c < NCH; c++) begin
        if (ch_done[c] && m_en[c]) m_fl[c] = 1;
        else if (wr && bus_wdata[24+c]) m_fl[c] = 0;
      end
      if (wr) begin
        m_force  = bus_wdata[15];
        m_en     = bus_wdata[22:16];
        m_master = bus_wdata[23];
      end
    end
  end

  function automatic logic [31:0] model_read();
    if (bus_addr != 8'h74) return 32'h0;
    return {m_sum, m_fl, m_master, m_en, m_force, 15'h0};
  endfunction

  always @(negedge clk) begin
    cycles++;
    vectors++;
    if (bus_rdata !== model_read() || irq !== m_irq) begin
      misses++;
      $display("FAIL %s: rdata=%08h irq=%0b expected rdata=%08h irq=%0b",
               tag, bus_rdata, irq, model_read(), m_irq);
    end
    if (cycles > WD_LIMIT) begin
      misses++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic step(input bit we, input logic [7:0] a, input logic [31:0] d,
                      input logic [6:0] dn);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; ch_done = dn;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h74, 32'h0, 7'h0);
  endtask

  initial begin
    tag = "R1";
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    idle(3);

    tag = "R2";
    step(1, 8'h74, 32'h00FF_FFFF, 7'h0);
    idle(4);
    step(1, 8'h74, 32'h0000_0000, 7'h0);
    idle(2);

    tag = "R8";
    step(1, 8'h74, 32'h0000_8000, 7'h0);
    idle(5);
    step(1, 8'h74, 32'h0000_0000, 7'h0);
    idle(3);

    tag = "R3";
    step(1, 8'h74, 32'h8000_0000, 7'h0);
    idle(3);

    tag = "R5";
    step(0, 8'h74, 32'h0, 7'h7F);
    idle(2);
    step(1, 8'h74, 32'h0005_0000, 7'h0);
    idle(1);
    step(0, 8'h74, 32'h0, 7'h7F);
    idle(2);

    tag = "R7";
    step(1, 8'h74, 32'h0085_0000, 7'h0);
    idle(4);

    tag = "R4";
    step(1, 8'h74, 32'h0085_0000, 7'h0);
    idle(2);
    step(1, 8'h74, 32'h0185_0000, 7'h0);
    idle(3);
    step(1, 8'h74, 32'h0485_0000, 7'h0);
    idle(3);

    tag = "R6";
    step(1, 8'h74, 32'h00FF_0000, 7'h0);
    step(1, 8'h74, 32'h0AFF_0000, 7'h0A);
    idle(3);
    step(1, 8'h74, 32'h7F80_0000, 7'h0);
    idle(3);

    tag = "R9";
    step(1, 8'h70, 32'hFFFF_FFFF, 7'h0);
    idle(2);
    step(0, 8'h70, 32'h0, 7'h0);
    step(0, 8'h78, 32'h0, 7'h0);
    idle(2);

    tag = "R7";
    for (int k = 0; k < 400; k++) begin
      logic [31:0] d;
      d = $urandom;
      step(($urandom % 3) == 0, (($urandom % 5) == 0) ? 8'h70 : 8'h74, d,
           7'($urandom) & 7'($urandom));
    end
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule